// File: doc/BRIEF.md
# Pipelined GF(2) Dot-Product Unit

This unit takes two equal-width bit vectors and produces one bit: the dot product over the two-element field. Each bit of the first vector is ANDed with the bit at the same index of the second, and the products are summed modulo 2, which is an XOR reduction. It is the inner-product engine for bit-matrix multiplication, where many copies run side by side and each one must take a new operand pair every clock.

The vectors are split into triples. A product cell folds three bit pairs into one partial parity, a function of six inputs. The partial parities then pass through a tree of six-input parity cells, with a register after each level. No level has more than six inputs, so the clock rate does not fall as the vector gets wider. Only the number of levels grows. With the default width of 96 there are 32 product cells, and the tree reduces them 32 → 6 → 1. A valid strobe travels beside the data with the same delay.

Top module: `gf2_dot_unit`

## Requirements
- R1: With `validIn` high at a clock edge, the result later delivered for that pair equals the parity of the bitwise AND of `aVec` and `bVec` (XOR of all bits of `aVec & bVec`).
- R2: Latency is one cycle for the product register plus one cycle per tree level. That is 3 cycles at the default width of 96. `validOut` is `validIn` delayed by exactly this latency.
- R3: A new pair is accepted on every clock edge with no stall. Back-to-back pairs each yield their own result, in the order they were presented, on consecutive cycles.
- R4: Only bits at the same index pair up. If both vectors have one bit set at the same index, the result is 1. If their single set bits are at different indices, the result is 0. All-zero vectors give 0, and all-one vectors give the parity of the width (0 at 96).
- R5: After reset is released and before any pair is presented, `validOut` is 0 and `resultBit` is 0.
- R6: Vector values applied while `validIn` is low are ignored. `validOut` stays low and `resultBit` keeps the last delivered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Marks `aVec`/`bVec` as a pair to process |
| aVec | input | VEC_W | First operand vector |
| bVec | input | VEC_W | Second operand vector |
| validOut | output | 1 | `resultBit` holds a new result |
| resultBit | output | 1 | Modulo-2 dot product |

## Verification
The hardest case to reach is a pipeline full of pairs with different results, where a stage that loads at the wrong time or skips a slot would mix neighbouring pairs. The stimulus sends long unbroken runs of random pairs, then runs with idle gaps of varied length in which garbage sits on the vector inputs. A scoreboard tags every expected bit with its due cycle, so both the value and the timing of each result are checked. Directed single-bit, all-zero and all-one pairs are included to catch products formed at the wrong index.

// File: rtl/gf2_dot_pkg.sv
package gf2_dot_pkg;

  localparam int MAX_LEVELS = 8;

  typedef struct packed {
    logic                  capture;
    logic [MAX_LEVELS-1:0] levelLoad;
  } dotStrobes_t;

  // Number of values left after lvl rounds of six-to-one reduction
  function automatic int levelWidth(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = (c + 5) / 6;
    return c;
  endfunction

  function automatic int treeLevels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 1) begin
      c = (c + 5) / 6;
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/gf2_mul_cell.sv
module gf2_mul_cell (
  input  logic [2:0] aTrip,
  input  logic [2:0] bTrip,
  output logic       prodBit
);
  assign prodBit = ^(aTrip & bTrip);
endmodule

// File: rtl/gf2_par6_cell.sv
module gf2_par6_cell (
  input  logic [5:0] inBits,
  output logic       parBit
);
  assign parBit = ^inBits;
endmodule

// File: rtl/gf2_dot_ctrl.sv
module gf2_dot_ctrl
  import gf2_dot_pkg::*;
#(
  parameter int NLEV = 2,
  localparam int LAT = NLEV + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  output dotStrobes_t stb,
  output logic        validOut
);
  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe[0] <= validIn;
      for (int s = 1; s < LAT; s++) validPipe[s] <= validPipe[s-1];
    end
  end

  always_comb begin
    stb.capture   = validIn;
    stb.levelLoad = '0;
    for (int l = 0; l < NLEV; l++) stb.levelLoad[l] = validPipe[l];
  end

  assign validOut = validPipe[LAT-1];

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> $past(validIn, LAT));

endmodule

// File: rtl/gf2_dot_dpath.sv
module gf2_dot_dpath
  import gf2_dot_pkg::*;
#(
  parameter int VEC_W = 96,
  localparam int NCELL = VEC_W / 3,
  localparam int NLEV  = treeLevels(NCELL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dotStrobes_t      stb,
  input  logic [VEC_W-1:0] aVec,
  input  logic [VEC_W-1:0] bVec,
  output logic             resultBit
);
  logic [NCELL-1:0] cellOut;
  logic [NCELL-1:0] prodQ;
  logic             lastLoad;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    gf2_mul_cell i_cell (
      .aTrip  (aVec[3*c +: 3]),
      .bTrip  (bVec[3*c +: 3]),
      .prodBit(cellOut[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            prodQ <= '0;
    else if (stb.capture) prodQ <= cellOut;
  end

  for (genvar lvl = 0; lvl < NLEV; lvl++) begin : g_lvl
    localparam int IN_W  = levelWidth(NCELL, lvl);
    localparam int OUT_W = levelWidth(NCELL, lvl + 1);
    logic [IN_W-1:0]    levelIn;
    logic [6*OUT_W-1:0] padded;
    logic [OUT_W-1:0]   sums;
    logic [OUT_W-1:0]   levelQ;

    if (lvl == 0) begin : g_first
      assign levelIn = prodQ;
    end else begin : g_next
      assign levelIn = g_lvl[lvl-1].levelQ;
    end

    assign padded = (6*OUT_W)'(levelIn);

    for (genvar o = 0; o < OUT_W; o++) begin : g_par
      gf2_par6_cell i_par (
        .inBits(padded[6*o +: 6]),
        .parBit(sums[o])
      );
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   levelQ <= '0;
      else if (stb.levelLoad[lvl]) levelQ <= sums;
    end
  end

  if (NLEV == 0) begin : g_noTree
    assign resultBit = prodQ[0];
    assign lastLoad  = stb.capture;
  end else begin : g_tree
    assign resultBit = g_lvl[NLEV-1].levelQ[0];
    assign lastLoad  = stb.levelLoad[NLEV-1];
  end

  // R1
  prod_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (^prodQ) == $past(^(aVec & bVec)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lastLoad |=> $stable(resultBit));

endmodule

// File: rtl/gf2_dot_unit.sv
module gf2_dot_unit
  import gf2_dot_pkg::*;
#(
  parameter int VEC_W = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [VEC_W-1:0] aVec,
  input  logic [VEC_W-1:0] bVec,
  output logic             validOut,
  output logic             resultBit
);
  localparam int NCELL = VEC_W / 3;
  localparam int NLEV  = treeLevels(NCELL);
  localparam int LAT   = NLEV + 1;

  if (VEC_W % 3 != 0 || NLEV > MAX_LEVELS) begin : g_badWidth
    $error("gf2_dot_unit: VEC_W must be a multiple of 3 within tree depth limit");
  end

  dotStrobes_t stb;

  gf2_dot_ctrl #(.NLEV(NLEV)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .stb     (stb),
    .validOut(validOut)
  );

  gf2_dot_dpath #(.VEC_W(VEC_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .aVec     (aVec),
    .bVec     (bVec),
    .resultBit(resultBit)
  );

  // R1
  result_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> resultBit == $past(^(aVec & bVec), LAT));

endmodule

// File: tb/test_gf2_dot_unit.sv
module test_gf2_dot_unit;
  localparam int VEC_W = 96;
  localparam int LAT   = 3;   // product register + two tree levels (32 -> 6 -> 1)

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             validIn = 1'b0;
  logic [VEC_W-1:0] aVec = '0;
  logic [VEC_W-1:0] bVec = '0;
  logic             validOut;
  logic             resultBit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit haveLast = 0;
  logic lastRes = 1'b0;
  logic expBitQ[$];
  int   expCycQ[$];

  gf2_dot_unit #(.VEC_W(VEC_W)) i_gf2_dot_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .aVec(aVec), .bVec(bVec),
    .validOut(validOut), .resultBit(resultBit)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [VEC_W-1:0] rndVec();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic send(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    @(posedge clk); #1;
    validIn = 1'b1; aVec = a; bVec = b;
    expBitQ.push_back(^(a & b));
    expCycQ.push_back(cyc + LAT);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      validIn = 1'b0; aVec = rndVec(); bVec = rndVec();
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (validOut) begin
        tests++;
        if (expBitQ.size() == 0) begin
          fails++;
          $display("FAIL R2: validOut high at cycle %0d, expected no result", cyc);
        end else begin
          logic e; int ec;
          e = expBitQ.pop_front(); ec = expCycQ.pop_front();
          if (ec != cyc) begin
            fails++;
            $display("FAIL R2/R3: result at cycle %0d, expected cycle %0d", cyc, ec);
          end else if (resultBit !== e) begin
            fails++;
            $display("FAIL R1: result %0b, expected %0b", resultBit, e);
          end
          lastRes = e; haveLast = 1;
        end
      end else if (haveLast) begin
        tests++;  // R6: output holds while no result is due
        if (resultBit !== lastRes) begin
          fails++;
          $display("FAIL R6: result %0b while idle, expected held %0b", resultBit, lastRes);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    tests++;  // R5
    if (validOut !== 1'b0 || resultBit !== 1'b0) begin
      fails++;
      $display("FAIL R5: validOut=%0b resultBit=%0b, expected 0 0", validOut, resultBit);
    end
    idle(2);
    // R4 directed patterns
    send('0, '0);
    send('1, '1);
    send('1, '0);
    for (int k = 0; k < VEC_W; k += 7) send(VEC_W'(1) << k, VEC_W'(1) << k);
    send(VEC_W'(1) << 5, VEC_W'(1) << 6);
    send(VEC_W'(1) << 0, VEC_W'(1) << (VEC_W-1));
    send({1'b1, {(VEC_W-1){1'b0}}}, '1);
    // R3 back-to-back random
    for (int i = 0; i < 300; i++) send(rndVec(), rndVec());
    // R6 gaps with garbage on the inputs
    for (int i = 0; i < 200; i++) begin
      send(rndVec(), rndVec());
      idle(i % 5);
    end
    // sparse-bit patterns
    for (int i = 0; i < 100; i++) send(rndVec() & rndVec(), rndVec() | rndVec());
    idle(LAT + 4);
    tests++;  // R3: every pair delivered
    if (expBitQ.size() != 0) begin
      fails++;
      $display("FAIL R3: %0d results missing, expected 0", expBitQ.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    tests++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule